// File: doc/BRIEF.md
# Indirect Clock-Synthesizer Register Port

This block gives a host a byte-wide way into a small bank of clock-synthesizer control registers. The host sees three byte ports, picked by a 2-bit port select: an address port, a data port and a clock-select port. An address byte holds a register index in bits 7:2 and a write-enable flag in bit 1; bit 0 is ignored. Once an index is latched, a data-port read returns that register and a data-port write stores into it, but only while the write-enable flag from the last address byte is set. A normal write is three steps: an address byte with the flag set, the data byte, then the address byte again with the flag cleared.

The bank holds two control bytes, a reference divider, a memory-clock feedback divider, a packed post-divider register, an extended control register and one 8-bit feedback divider per selectable pixel clock. The clock-select port chooses which pixel clock is active. The block presents that clock's feedback divider and its 3-bit post-divider setting (extended bit plus 2-bit code) on dedicated outputs. Analog behaviour and lock detection belong to other blocks.

An access sequencer tracks the write window with three named states. ST_LOCKED means writes are shut. ST_OPEN means an enabled address byte has arrived and no data has yet been written. ST_DONE means at least one data byte has been committed while the window is still open. The transitions are:
- LOCKED to OPEN on an address write with the flag set.
- OPEN to DONE on a data write.
- OPEN or DONE to LOCKED on an address write with the flag clear.
- DONE to OPEN on an address write with the flag set.
- In every other case the state holds.

Top module: `pll_reg_port`

## Requirements
- R1: After reset, every register reads 0 except the general control byte (index 0) and the pixel-clock control byte (index 1), which take the parameter values GEN_RST and VCLK_RST. The active clock is 0 and the read data is 0.
- R2: An address-port write (host_sel=0) latches bits 7:2 as the register index and bit 1 as the write-enable flag, and ignores bit 0. A read of the address port returns {index, flag, 1'b0}.
- R3: A data-port write (host_sel=1) stores host_wdata into the indexed register only if the latched flag is 1. With the flag 0, no register changes.
- R4: A read (host_rd) updates host_rdata at the next clock edge with the selected port's value; the data port returns the indexed register. At all other times host_rdata holds its value, and reads change no register.
- R5: Indices at or above FB_BASE+NUM_CLK (10 by default) read as 0, and writes to them change no register. Port select 3 reads as 0 and ignores writes.
- R6: The post-divider register (index 4) holds clock n's 2-bit code in bits 2n+1:2n. act_post[1:0] shows the active clock's field.
- R7: Clock n's feedback divider is the register at index FB_BASE+n (6+n by default). act_fbdiv shows the active clock's divider.
- R8: In the extended control register (index 5), bit 4+n is clock n's extra post-divider bit, and act_post[2] shows it for the active clock. The low nibble is kept as written and is shown on ext_ctl.
- R9: A clock-select write (host_sel=2) loads bits 1:0 as the active clock only when strobe bit 7 is 1; otherwise the active clock is unchanged. A read of this port returns the active clock number zero-extended.
- R10: The write window stays open across any number of data writes until an address byte with the flag clear is written. After that, data writes are ignored.
- R11: Index 0 to 3 appear on gen_ctl, vclk_ctl, ref_div and mem_fbdiv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 2 | Port select: 0 address, 1 data, 2 clock select, 3 unused |
| host_wr | input | 1 | Write strobe for the selected port |
| host_rd | input | 1 | Read strobe for the selected port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| act_clk | output | 2 | Active pixel clock number |
| act_post | output | 3 | Active clock post-divider setting {extra bit, code} |
| act_fbdiv | output | 8 | Active clock feedback divider |
| gen_ctl | output | 8 | General control byte (index 0) |
| vclk_ctl | output | 8 | Pixel-clock control byte (index 1) |
| ref_div | output | 8 | Reference divider (index 2) |
| mem_fbdiv | output | 8 | Memory-clock feedback divider (index 3) |
| ext_ctl | output | 8 | Extended control register (index 5) |

## Verification
The bench first fills the post-divider register one field at a time by read-modify-write. It then steps the active clock through all four values. A design with a wrong field shift would show another clock's code on act_post, and a design that wrote the whole byte would erase neighbouring fields. The bench also sends data bytes after the flag is closed, sends data to indices 10 and 63, and sends a clock-select write without the strobe. A design that fails to gate any of these would change an output register that the behavioural model holds fixed. Finally, the bench checks that bit 0 of the address byte is ignored and that several writes can go through a single open window. These two checks catch an index decode off by one bit and a window that closes after the first write.

// File: rtl/pllrp_pkg.sv
package pllrp_pkg;
    localparam int BYTE_W  = 8;
    localparam int IDX_LSB = 2;
    localparam int IDX_W   = BYTE_W - IDX_LSB;
    localparam int EN_BIT  = 1;
    localparam int STB_BIT = 7;
    localparam int EXT_LSB = 4;

    localparam int IDX_GEN  = 0;
    localparam int IDX_VCTL = 1;
    localparam int IDX_REF  = 2;
    localparam int IDX_MFB  = 3;
    localparam int IDX_POST = 4;
    localparam int IDX_EXT  = 5;

    typedef enum logic [1:0] {
        PORT_ADDR = 2'd0,
        PORT_DATA = 2'd1,
        PORT_CLK  = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_DONE   = 2'd2
    } acc_state_e;
endpackage

// File: rtl/pllrp_seq.sv
module pllrp_seq
    import pllrp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_wr,
    input  logic             data_wr,
    input  logic [IDX_W-1:0] new_idx,
    input  logic             new_en,
    output logic [IDX_W-1:0] cur_idx,
    output logic             cur_en,
    output logic             commit
);
    acc_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOCKED: if (addr_wr && new_en) nxt = ST_OPEN;
            ST_OPEN: begin
                if (addr_wr)      nxt = new_en ? ST_OPEN : ST_LOCKED;
                else if (data_wr) nxt = ST_DONE;
            end
            ST_DONE: if (addr_wr) nxt = new_en ? ST_OPEN : ST_LOCKED;
            default: nxt = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_LOCKED;
            cur_idx <= '0;
        end else begin
            state <= nxt;
            if (addr_wr) cur_idx <= new_idx;
        end
    end

    always_comb begin
        cur_en = (state != ST_LOCKED);
        commit = data_wr && (state != ST_LOCKED);
    end

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && new_en) |=> (state == ST_OPEN));
    p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && !new_en) |=> (state == ST_LOCKED && !commit));
    p_stay_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !addr_wr && state != ST_LOCKED) |=> (state == ST_DONE));
endmodule

// File: rtl/pllrp_bank.sv
module pllrp_bank
    import pllrp_pkg::*;
#(
    parameter int                NUM_CLK  = 4,
    parameter int                FB_BASE  = 6,
    parameter logic [BYTE_W-1:0] GEN_RST  = 8'h00,
    parameter logic [BYTE_W-1:0] VCLK_RST = 8'h00,
    localparam int               NUM_REGS = FB_BASE + NUM_CLK
)(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             commit,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [BYTE_W-1:0]                wdata,
    output logic [BYTE_W-1:0]                rd_val,
    output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [BYTE_W-1:0] RV =
            (i == IDX_GEN)  ? GEN_RST  :
            (i == IDX_VCTL) ? VCLK_RST : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= RV;
            else if (commit && idx == IDX_W'(i))
                regs[i] <= wdata;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (idx == IDX_W'(i)) rd_val = regs[i];
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs));
    p_oob_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && idx >= IDX_W'(NUM_REGS)) |=> $stable(regs));
endmodule

// File: rtl/pllrp_clksel.sv
module pllrp_clksel
    import pllrp_pkg::*;
#(
    parameter int  NUM_CLK = 4,
    localparam int CLK_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
)(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sel_wr,
    input  logic                            sel_stb,
    input  logic [CLK_W-1:0]                sel_num,
    input  logic [2*NUM_CLK-1:0]            post_reg,
    input  logic [NUM_CLK-1:0]              ext_bits,
    input  logic [NUM_CLK-1:0][BYTE_W-1:0]  fb_regs,
    output logic [CLK_W-1:0]                act,
    output logic [2:0]                      act_post,
    output logic [BYTE_W-1:0]               act_fb
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                act <= '0;
        else if (sel_wr && sel_stb) act <= sel_num;
    end

    always_comb begin
        act_post = {ext_bits[act], post_reg[2*act +: 2]};
        act_fb   = fb_regs[act];
    end

    p_nostrobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !sel_stb) |=> $stable(act));
endmodule

// File: rtl/pll_reg_port.sv
module pll_reg_port
    import pllrp_pkg::*;
#(
    parameter int                NUM_CLK  = 4,
    parameter int                FB_BASE  = 6,
    parameter logic [BYTE_W-1:0] GEN_RST  = 8'h00,
    parameter logic [BYTE_W-1:0] VCLK_RST = 8'h00,
    localparam int               CLK_W    = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1,
    localparam int               NUM_REGS = FB_BASE + NUM_CLK
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic [CLK_W-1:0]  act_clk,
    output logic [2:0]        act_post,
    output logic [BYTE_W-1:0] act_fbdiv,
    output logic [BYTE_W-1:0] gen_ctl,
    output logic [BYTE_W-1:0] vclk_ctl,
    output logic [BYTE_W-1:0] ref_div,
    output logic [BYTE_W-1:0] mem_fbdiv,
    output logic [BYTE_W-1:0] ext_ctl
);
    port_e port;
    logic addr_wr, data_wr, clk_wr, commit, cur_en;
    logic [IDX_W-1:0]  cur_idx;
    logic [BYTE_W-1:0] bank_rd;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
    logic [NUM_CLK-1:0][BYTE_W-1:0]  fb_regs;

    always_comb begin
        port    = port_e'(host_sel);
        addr_wr = host_wr && port == PORT_ADDR;
        data_wr = host_wr && port == PORT_DATA;
        clk_wr  = host_wr && port == PORT_CLK;
    end

    pllrp_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .addr_wr(addr_wr), .data_wr(data_wr),
        .new_idx(host_wdata[BYTE_W-1:IDX_LSB]), .new_en(host_wdata[EN_BIT]),
        .cur_idx(cur_idx), .cur_en(cur_en), .commit(commit)
    );

    pllrp_bank #(
        .NUM_CLK(NUM_CLK), .FB_BASE(FB_BASE),
        .GEN_RST(GEN_RST), .VCLK_RST(VCLK_RST)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .commit(commit), .idx(cur_idx),
        .wdata(host_wdata), .rd_val(bank_rd), .regs(regs)
    );

    for (genvar n = 0; n < NUM_CLK; n++) begin : g_fb
        assign fb_regs[n] = regs[FB_BASE + n];
    end

    pllrp_clksel #(.NUM_CLK(NUM_CLK)) u_clksel (
        .clk(clk), .rst_n(rst_n),
        .sel_wr(clk_wr), .sel_stb(host_wdata[STB_BIT]),
        .sel_num(host_wdata[CLK_W-1:0]),
        .post_reg(regs[IDX_POST][2*NUM_CLK-1:0]),
        .ext_bits(regs[IDX_EXT][EXT_LSB +: NUM_CLK]),
        .fb_regs(fb_regs),
        .act(act_clk), .act_post(act_post), .act_fb(act_fbdiv)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_rdata <= '0;
        else if (host_rd) begin
            unique case (port)
                PORT_ADDR: host_rdata <= {cur_idx, cur_en, 1'b0};
                PORT_DATA: host_rdata <= bank_rd;
                PORT_CLK:  host_rdata <= BYTE_W'(act_clk);
                default:   host_rdata <= '0;
            endcase
        end
    end

    always_comb begin
        gen_ctl   = regs[IDX_GEN];
        vclk_ctl  = regs[IDX_VCTL];
        ref_div   = regs[IDX_REF];
        mem_fbdiv = regs[IDX_MFB];
        ext_ctl   = regs[IDX_EXT];
    end

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/pll_reg_port_tb_top.sv
module pll_reg_port_tb_top;
    localparam logic [7:0] GEN_RV  = 8'hA5;
    localparam logic [7:0] VCLK_RV = 8'h03;
    localparam int NREG = 10;

    logic clk = 0, rst_n = 0;
    logic [1:0] host_sel = 0;
    logic host_wr = 0, host_rd = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic [1:0] act_clk;
    logic [2:0] act_post;
    logic [7:0] act_fbdiv, gen_ctl, vclk_ctl, ref_div, mem_fbdiv, ext_ctl;

    int n_cmp = 0, n_bad = 0;
    int m_reg [0:15];
    int m_idx = 0, m_en = 0, m_act = 0, m_rd = 0;

    always #10 clk = ~clk;

    pll_reg_port #(.GEN_RST(GEN_RV), .VCLK_RST(VCLK_RV)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .act_clk(act_clk), .act_post(act_post), .act_fbdiv(act_fbdiv),
        .gen_ctl(gen_ctl), .vclk_ctl(vclk_ctl), .ref_div(ref_div),
        .mem_fbdiv(mem_fbdiv), .ext_ctl(ext_ctl)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, compared on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 rdata", host_rdata, m_rd);
            chk("R9 act_clk", act_clk, m_act);
            chk("R6 post code", act_post[1:0], (m_reg[4] >> (2*m_act)) & 3);
            chk("R8 ext bit", act_post[2], (m_reg[5] >> (4+m_act)) & 1);
            chk("R7 fbdiv", act_fbdiv, m_reg[6+m_act]);
            chk("R11 gen", gen_ctl, m_reg[0]);
            chk("R11 vclk", vclk_ctl, m_reg[1]);
            chk("R11 ref", ref_div, m_reg[2]);
            chk("R11 mfb", mem_fbdiv, m_reg[3]);
            chk("R8 ext", ext_ctl, m_reg[5]);
        end
    end

    task automatic wr(int sel, int d);
        @(negedge clk);
        host_sel = 2'(sel); host_wdata = 8'(d); host_wr = 1;
        @(posedge clk); #1;
        host_wr = 0;
        case (sel)
            0: begin m_idx = (d >> 2) & 63; m_en = (d >> 1) & 1; end
            1: if (m_en == 1 && m_idx < NREG) m_reg[m_idx] = d & 255;
            2: if (((d >> 7) & 1) == 1) m_act = d & 3;
            default: ;
        endcase
    endtask

    task automatic rd(int sel, string tag, int exp);
        @(negedge clk);
        host_sel = 2'(sel); host_rd = 1;
        @(posedge clk); #1;
        host_rd = 0;
        case (sel)
            0: m_rd = (m_idx << 2) | (m_en << 1);
            1: m_rd = (m_idx < NREG) ? m_reg[m_idx] : 0;
            2: m_rd = m_act;
            default: m_rd = 0;
        endcase
        @(negedge clk);
        chk(tag, host_rdata, exp);
    endtask

    task automatic put(int idx, int d);
        wr(0, (idx << 2) | 2);
        wr(1, d);
        wr(0, idx << 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = 0;
        m_reg[0] = GEN_RV; m_reg[1] = VCLK_RV;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 gen", gen_ctl, GEN_RV);
        chk("R1 vclk", vclk_ctl, VCLK_RV);
        chk("R1 ref", ref_div, 0);
        chk("R1 act_clk", act_clk, 0);
        chk("R1 rdata", host_rdata, 0);
        rst_n = 1;
        rd(1, "R1 read idx0", GEN_RV);

        // R2 address byte, bit0 ignored
        wr(0, 8'h0B);
        rd(0, "R2 addr readback", 8'h0A);
        wr(1, 8'h5C);
        wr(0, 8'h09);
        rd(1, "R4 read ref", 8'h5C);
        // R3 write with flag clear ignored
        wr(1, 8'hFF);
        rd(1, "R3 closed write", 8'h5C);

        // R10 multiple writes in one window
        wr(0, (3 << 2) | 2);
        wr(1, 8'h11);
        wr(1, 8'h22);
        rd(1, "R10 second write", 8'h22);
        wr(0, 3 << 2);
        wr(1, 8'h77);
        rd(1, "R10 after close", 8'h22);

        // R6 post-divider fields by read-modify-write
        for (int n = 0; n < 4; n++) begin
            int cur;
            wr(0, 4 << 2);
            rd(1, "R6 rmw read", m_reg[4]);
            cur = host_rdata;
            cur = (cur & ~(3 << (2*n))) | (((n + 1) & 3) << (2*n));
            wr(0, (4 << 2) | 2);
            wr(1, cur);
            wr(0, 4 << 2);
        end
        rd(1, "R6 packed", 8'h39);

        // R8 extended bits, R7 feedback dividers
        put(5, 8'h5A);
        for (int n = 0; n < 4; n++) put(6 + n, 8'h80 + n * 8'h11);
        for (int n = 0; n < 4; n++) begin
            wr(2, 8'h80 | n);
            @(negedge clk);
            chk("R6 act code", act_post[1:0], (n + 1) & 3);
            chk("R8 act ext", act_post[2], (n == 0 || n == 2) ? 1 : 0);
            chk("R7 act fb", act_fbdiv, 8'h80 + n * 8'h11);
        end

        // R9 strobe required
        wr(2, 8'h81);
        wr(2, 8'h02);
        rd(2, "R9 no strobe", 1);
        wr(2, 8'h83);
        rd(2, "R9 strobe", 3);

        // R5 out-of-range indices and unused port
        put(10, 8'hEE);
        rd(1, "R5 idx10", 0);
        put(63, 8'hEE);
        rd(1, "R5 idx63", 0);
        wr(3, 8'hFF);
        rd(3, "R5 port3", 0);
        wr(0, 2 << 2);
        rd(1, "R5 ref intact", 8'h5C);
        put(1, 8'h3C);
        rd(1, "R11 vclk write", 8'h3C);

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule